// File: doc/BRIEF.md
# Vector Lane Predication Controller

This block decides, for each vector instruction, which of the sixteen byte lanes of a 128-bit vector are allowed to write their result. It merges four independent sources of suppression into one 16-bit active mask. The sources are a stored per-byte predicate with two 4-bit block-mask fields, truncation of the last iteration of a tail-predicated loop, and a beat-skip state that marks beats already retired before an interrupted instruction resumed. Lane consumers read the mask at their element stride: every bit for bytes, even bits for halfwords, and bits 0, 4, 8 and 12 for words.

The block also computes the state that the predicate register and the condition/beat-skip byte take after the instruction. When the completion strobe is low, both values pass through unchanged. All outputs are registered, so they appear one clock after the inputs are presented.

Top module: `lane_pred_ctrl`

## Requirements
- R1: While reset is asserted, the mask, next predicate, next condition byte and error output are all zero.
- R2: The predicate register holds the byte predicate in bits 15:0, the low block-mask field in bits 19:16 and the high block-mask field in bits 23:20. With no other source active, the mask equals bits 15:0, one clock after the inputs.
- R3: A low block-mask field of zero forces mask bits 7:0 to one. A high field of zero forces mask bits 15:8 to one. The two halves are handled independently.
- R4: When the size code is below 4 and the loop count is at most 1<<(4-size), only the lowest count<<size mask bits are kept and the rest are cleared. A count of zero clears the whole mask. A size code of 4 or more, or a larger count, has no effect.
- R5: When bits 3:0 of the condition byte are zero, bits 7:4 are a beat-skip code. Code 0 leaves the mask alone, code 1 clears bits 3:0, code 2 clears bits 7:0, and codes 4 and 5 clear bits 11:0. When bits 3:0 are non-zero, the code is ignored.
- R6: A beat-skip code other than 0, 1, 2, 4 or 5, seen while bits 3:0 are zero, raises the error output and zeroes the mask.
- R7: With the completion strobe low, the next predicate equals the input predicate and the next condition byte equals the input condition byte.
- R8: On completion with condition bits 3:0 zero, the next condition byte is 8'h10 if the code was 5 and 8'h00 otherwise. With bits 3:0 non-zero, the byte is unchanged.
- R9: On completion with both block-mask fields zero, the next predicate equals the input predicate.
- R10: On completion with either field non-zero, a field greater than 8 inverts its half of bits 15:0. Each field then becomes its value shifted left by one, truncated to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_i | input | 24 | Predicate register: byte predicate, low and high block-mask fields |
| loop_cnt_i | input | CNT_W | Remaining loop element count |
| tail_sz_i | input | 3 | Tail element-size code; 4 or more disables tail predication |
| cond_i | input | 8 | Condition byte; beat-skip code in 7:4 when 3:0 is zero |
| done_i | input | 1 | Instruction-complete strobe |
| lane_mask_o | output | 16 | Byte-lane active mask, 1 = active |
| pred_o | output | 24 | Next predicate register value |
| cond_o | output | 8 | Next condition/beat-skip byte |
| skip_err_o | output | 1 | Invalid beat-skip code seen |

## Verification
Every combination of the two block-mask fields is applied with the completion strobe high. This separates the half-forcing rule from the inversion threshold at 8 and from the shift, including the cases where exactly one field is zero. The tail sweep crosses every size code with counts from zero to past the threshold and with a very large count. This tells a correct length computation apart from an off-by-one boundary and shows that size codes 4 and up are ignored. All sixteen skip codes are tried with the low condition nibble both zero and non-zero, which separates valid codes, invalid codes and the ignore case, and shows the resume transition from code 5 to code 1. Walking-one predicates and pass-through vectors with the strobe low show that the base mask and the held state are carried bit for bit.

// File: rtl/lane_pred_ctrl.sv
module lane_pred_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [23:0]      pred_i,
  input  logic [CNT_W-1:0] loop_cnt_i,
  input  logic [2:0]       tail_sz_i,
  input  logic [7:0]       cond_i,
  input  logic             done_i,
  output logic [15:0]      lane_mask_o,
  output logic [23:0]      pred_o,
  output logic [7:0]       cond_o,
  output logic             skip_err_o
);
  localparam int LANES = 16;
  localparam int HALF  = LANES / 2;

  wire [3:0] blk_lo  = pred_i[19:16];
  wire [3:0] blk_hi  = pred_i[23:20];
  wire       skip_on = (cond_i[3:0] == 4'd0);
  wire [3:0] skip_cd = cond_i[7:4];

  wire [LANES-1:0] base_m = pred_i[15:0] | {{HALF{blk_hi == 4'd0}}, {HALF{blk_lo == 4'd0}}};

  logic [LANES-1:0] tail_m, skip_m, mask_d;
  logic [4:0]       tail_len;
  logic             bad_d;

  always_comb begin
    tail_m   = '1;
    tail_len = '0;
    if (tail_sz_i < 3'd4 && loop_cnt_i <= (CNT_W'(1) << (3'd4 - tail_sz_i))) begin
      tail_len = loop_cnt_i[4:0] << tail_sz_i[1:0];
      tail_m   = 16'((17'd1 << tail_len) - 17'd1);
    end
  end

  always_comb begin
    skip_m = '1;
    bad_d  = 1'b0;
    if (skip_on) begin
      case (skip_cd)
        4'd0:       skip_m = 16'hffff;
        4'd1:       skip_m = 16'hfff0;
        4'd2:       skip_m = 16'hff00;
        4'd4, 4'd5: skip_m = 16'hf000;
        default:    bad_d  = 1'b1;
      endcase
    end
  end

  assign mask_d = bad_d ? '0 : (base_m & tail_m & skip_m);

  wire [LANES-1:0] inv_m    = {{HALF{blk_hi > 4'd8}}, {HALF{blk_lo > 4'd8}}};
  wire [23:0]      pred_adv = {blk_hi[2:0], 1'b0, blk_lo[2:0], 1'b0, pred_i[15:0] ^ inv_m};
  wire [23:0]      pred_d   = (done_i && pred_i[23:16] != 8'd0) ? pred_adv : pred_i;
  wire [7:0]       cond_d   = (done_i && skip_on) ? ((skip_cd == 4'd5) ? 8'h10 : 8'h00) : cond_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_mask_o <= '0;
      pred_o      <= '0;
      cond_o      <= '0;
      skip_err_o  <= 1'b0;
    end else begin
      lane_mask_o <= mask_d;
      pred_o      <= pred_d;
      cond_o      <= cond_d;
      skip_err_o  <= bad_d;
    end
  end
endmodule

module lane_pred_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [23:0]      pred_i,
  input logic [CNT_W-1:0] loop_cnt_i,
  input logic [2:0]       tail_sz_i,
  input logic [7:0]       cond_i,
  input logic             done_i,
  input logic [15:0]      lane_mask_o,
  input logic [23:0]      pred_o,
  input logic [7:0]       cond_o,
  input logic             skip_err_o
);
  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r5_skip_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(cond_i == 8'h10) |-> lane_mask_o[3:0] == 4'd0);

  a_r6_error_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    skip_err_o |-> lane_mask_o == 16'd0);

  a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(tail_sz_i == 3'd0 && loop_cnt_i == '0) |-> lane_mask_o == 16'd0);

  a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(!done_i) |-> (pred_o == $past(pred_i) && cond_o == $past(cond_i)));

  a_r9_pred_keep: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(done_i && pred_i[23:16] == 8'd0) |-> pred_o == $past(pred_i));

  a_r8_resume_state: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(done_i && cond_i[3:0] == 4'd0) |-> (cond_o == 8'h00 || cond_o == 8'h10));
endmodule

bind lane_pred_ctrl lane_pred_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .loop_cnt_i(loop_cnt_i),
  .tail_sz_i(tail_sz_i), .cond_i(cond_i), .done_i(done_i),
  .lane_mask_o(lane_mask_o), .pred_o(pred_o), .cond_o(cond_o),
  .skip_err_o(skip_err_o)
);

// File: tb/lane_pred_ctrl_test.sv
module lane_pred_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pred_i = '0;
  logic [31:0] loop_cnt_i = '0;
  logic [2:0]  tail_sz_i = 3'd4;
  logic [7:0]  cond_i = 8'h01;
  logic        done_i = 1'b0;
  logic [15:0] lane_mask_o;
  logic [23:0] pred_o;
  logic [7:0]  cond_o;
  logic        skip_err_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lane_pred_ctrl #(.CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .pred_i(pred_i), .loop_cnt_i(loop_cnt_i),
    .tail_sz_i(tail_sz_i), .cond_i(cond_i), .done_i(done_i),
    .lane_mask_o(lane_mask_o), .pred_o(pred_o), .cond_o(cond_o),
    .skip_err_o(skip_err_o)
  );

  function automatic bit code_ok(input logic [7:0] c);
    int k = int'(c[7:4]);
    return (c[3:0] != 0) || k == 0 || k == 1 || k == 2 || k == 4 || k == 5;
  endfunction

  function automatic logic [15:0] exp_mask(input logic [23:0] p, input logic [31:0] n,
                                           input logic [2:0] s, input logic [7:0] c);
    logic [15:0] m;
    int lo_bound = 0;
    bit tail = (s < 4) && (n <= (32'd1 << (4 - s)));
    longint keep = longint'(n) * (longint'(1) << s);
    if (!code_ok(c)) return 16'd0;
    if (c[3:0] == 0) begin
      case (int'(c[7:4]))
        1: lo_bound = 4;
        2: lo_bound = 8;
        4, 5: lo_bound = 12;
        default: lo_bound = 0;
      endcase
    end
    for (int b = 0; b < 16; b++) begin
      bit on = p[b] || (b < 8 ? p[19:16] == 0 : p[23:20] == 0);
      if (tail && b >= keep) on = 0;
      if (b < lo_bound) on = 0;
      m[b] = on;
    end
    return m;
  endfunction

  function automatic logic [23:0] exp_pred(input logic [23:0] p, input logic d);
    logic [23:0] r;
    int lo = int'(p[19:16]);
    int hi = int'(p[23:20]);
    if (!d || (lo == 0 && hi == 0)) return p;
    r[15:0] = p[15:0];
    if (lo > 8) r[7:0] = ~p[7:0];
    if (hi > 8) r[15:8] = ~p[15:8];
    r[19:16] = 4'((lo * 2) % 16);
    r[23:20] = 4'((hi * 2) % 16);
    return r;
  endfunction

  function automatic logic [7:0] exp_cond(input logic [7:0] c, input logic d);
    if (!d || c[3:0] != 0) return c;
    return (c[7:4] == 4'd5) ? 8'h10 : 8'h00;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic vec(input logic [23:0] p, input logic [31:0] n, input logic [2:0] s,
                     input logic [7:0] c, input logic d, input string tm, input string tp);
    logic [15:0] em = exp_mask(p, n, s, c);
    logic [23:0] ep = exp_pred(p, d);
    logic [7:0]  ec = exp_cond(c, d);
    bit          ee = !code_ok(c);
    pred_i = p; loop_cnt_i = n; tail_sz_i = s; cond_i = c; done_i = d;
    @(negedge clk);
    chk({tm, " mask"}, int'(lane_mask_o), int'(em));
    chk("R6 err", int'(skip_err_o), int'(ee));
    chk(d ? {tp, " pred"} : "R7 pred", int'(pred_o), int'(ep));
    chk(d ? "R8 cond" : "R7 cond", int'(cond_o), int'(ec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mask", int'(lane_mask_o), 0);
    chk("R1 pred", int'(pred_o), 0);
    chk("R1 cond", int'(cond_o), 0);
    chk("R1 err", int'(skip_err_o), 0);
    rst_n = 1'b1;

    // R2: base predicate passes through
    for (int b = 0; b < 16; b++)
      vec({8'h88, 16'(1 << b)}, 32'd100, 3'd4, 8'h01, 1'b0, "R2", "R7");
    vec(24'h88a5c3, 32'd0, 3'd4, 8'h03, 1'b0, "R2", "R7");
    vec(24'h11ffff, 32'd5, 3'd7, 8'h21, 1'b0, "R2", "R7");

    // R3, R9, R10: all block-field pairs on completion
    for (int lo = 0; lo < 16; lo++)
      for (int hi = 0; hi < 16; hi++)
        vec({4'(hi), 4'(lo), 16'h3c96 ^ 16'(lo * 16'h0101)}, 32'd50, 3'd4, 8'h00, 1'b1,
            "R3", (lo == 0 && hi == 0) ? "R9" : "R10");

    // R4: tail truncation across sizes and counts
    for (int s = 0; s < 6; s++) begin
      for (int n = 0; n < 21; n++)
        vec(24'h88ffff, 32'(n), 3'(s), 8'h01, 1'b0, "R4", "R7");
      vec(24'h000000, 32'h0001_0000, 3'(s), 8'h01, 1'b0, "R4", "R7");
    end

    // R5, R6, R8: every skip code, nibble zero and non-zero
    for (int k = 0; k < 16; k++) begin
      bit ok = (k == 0 || k == 1 || k == 2 || k == 4 || k == 5);
      vec(24'h44ffff, 32'd9, 3'd4, {4'(k), 4'h0}, 1'b1, ok ? "R5" : "R6", "R10");
      vec(24'h44ffff, 32'd9, 3'd4, {4'(k), 4'h3}, 1'b1, "R5", "R10");
      vec(24'h000000, 32'd2, 3'd2, {4'(k), 4'h0}, 1'b0, ok ? "R5" : "R6", "R7");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule